// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small associative store of `NUM_WORDS` entries, each `WORD_W` bits wide. It is searched by value rather than by location. A search compares every stored entry against a held search value in the same cycle. A held mask decides which bit columns take part: a column whose mask bit is 1 must agree, and a column whose mask bit is 0 is ignored. The outcome is one hit bit per entry, captured in a match register.

Entries are loaded by index, and each load also sets or clears a per-entry valid flag. A readout step returns the contents of the lowest-numbered entry whose hit bit is set. When no hit bit is set, the readout step raises a miss flag instead. The search value and the mask each sit in their own register and are reloaded only on request. One search therefore takes a single strobe, and a read needs one more strobe after it.

Top module: `cam_top`

## Requirements
- R1: After reset, `matchVec`, `rdData` and `noMatch` are all zero, and every entry is invalid.
- R2: On the clock edge where `searchStb` is high, each bit i of `matchVec` becomes 1 exactly when entry i is valid and agrees with the search register in every column where the mask register holds 1. All entries are compared in that one edge.
- R3: A mask of all zeros makes every valid entry hit.
- R4: An entry whose valid flag is 0 never sets its `matchVec` bit.
- R5: `matchVec` changes only on an edge where `searchStb` is high. At every other edge it holds its value.
- R6: When `wrEn` is high at an edge, entry `wrIdx` takes `wrData` and valid flag `wrValid`. Indices of `NUM_WORDS` or more are ignored. A search at the same edge still sees the entry's old contents.
- R7: When `rdStb` is high at an edge and `matchVec` is nonzero, `rdData` takes the contents of the lowest-index entry with a set `matchVec` bit, and `noMatch` goes to 0. `rdData` and `noMatch` change only on edges where `rdStb` is high.
- R8: When `rdStb` is high at an edge and `matchVec` is zero, `noMatch` goes to 1 and `rdData` goes to 0.
- R9: The search register loads `argIn` on an edge with `loadArg` high, and the mask register loads `keyIn` on an edge with `loadKey` high. A search at the same edge uses the values held before that load.
- R10: Suppose the search value is 101111100 and the mask is 111000000. Then an entry holding 100111100 does not hit, and an entry holding 101000011 does hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| loadArg | input | 1 | Load the search register from argIn |
| argIn | input | WORD_W | New search value |
| loadKey | input | 1 | Load the mask register from keyIn |
| keyIn | input | WORD_W | New column mask |
| wrEn | input | 1 | Write one entry |
| wrIdx | input | IDX_W | Entry index for the write |
| wrData | input | WORD_W | Entry contents to store |
| wrValid | input | 1 | Valid flag to store with the entry |
| searchStb | input | 1 | Compare all entries and capture the hit bits |
| rdStb | input | 1 | Read out the lowest-index hit entry |
| matchVec | output | NUM_WORDS | Match register, one bit per entry |
| rdData | output | WORD_W | Contents of the entry returned by the last readout |
| noMatch | output | 1 | Last readout found no hit |

## Verification
The bound checker watches several rules on every cycle. The match register must hold unless a search is strobed. The readout outputs must hold unless a read is strobed. Empty and non-empty reads must drive the miss flag in the right direction. A tracked copy of the valid flags must never allow an invalid entry to hit. Other behaviours can only be shown by bench scenarios with known contents. These are the column masking itself, the worked example, the choice of the lowest-index entry, and the old-value rules when a load, a write and a search fall on the same edge.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef struct packed {
    logic ldArg;
    logic ldKey;
    logic wr;
    logic search;
    logic rd;
  } camStrobe_t;
endpackage

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             loadArg,
  input  logic             loadKey,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             searchStb,
  input  logic             rdStb,
  output camStrobe_t       strobes
);
  localparam logic [IDX_W:0] ENTRY_LIMIT = (IDX_W + 1)'(NUM_WORDS);

  logic idxInRange;
  assign idxInRange = ({1'b0, wrIdx} < ENTRY_LIMIT);

  always_comb begin
    strobes.ldArg  = loadArg;
    strobes.ldKey  = loadKey;
    strobes.wr     = wrEn && idxInRange;
    strobes.search = searchStb;
    strobes.rd     = rdStb;
  end
endmodule

// File: rtl/cam_datapath.sv
module cam_datapath
  import cam_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 9,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  camStrobe_t           strobes,
  input  logic [WORD_W-1:0]    argIn,
  input  logic [WORD_W-1:0]    keyIn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [WORD_W-1:0]    wrData,
  input  logic                 wrValid,
  output logic [NUM_WORDS-1:0] matchVec,
  output logic [WORD_W-1:0]    rdData,
  output logic                 noMatch
);
  logic [WORD_W-1:0]    argReg, keyReg;
  logic [WORD_W-1:0]    wordData [NUM_WORDS];
  logic [NUM_WORDS-1:0] wordValid;
  logic [NUM_WORDS-1:0] hitNext;
  logic [NUM_WORDS-1:0] matchReg;
  logic [WORD_W-1:0]    firstData;
  logic                 anyHit;

  // parallel masked compare, one slice per entry
  for (genvar g = 0; g < NUM_WORDS; g++) begin : gCompare
    assign hitNext[g] = wordValid[g] && (((wordData[g] ^ argReg) & keyReg) == '0);
  end

  // lowest index wins: scan downward so the last assignment is the smallest hit
  always_comb begin
    firstData = '0;
    for (int i = NUM_WORDS - 1; i >= 0; i--) begin
      if (matchReg[i]) firstData = wordData[i];
    end
    anyHit = |matchReg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      argReg <= '0;
      keyReg <= '0;
    end else begin
      if (strobes.ldArg) argReg <= argIn;
      if (strobes.ldKey) keyReg <= keyIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordValid <= '0;
      for (int i = 0; i < NUM_WORDS; i++) wordData[i] <= '0;
    end else if (strobes.wr) begin
      wordData[wrIdx]  <= wrData;
      wordValid[wrIdx] <= wrValid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      matchReg <= '0;
      rdData   <= '0;
      noMatch  <= 1'b0;
    end else begin
      if (strobes.search) matchReg <= hitNext;
      if (strobes.rd) begin
        rdData  <= firstData;
        noMatch <= !anyHit;
      end
    end
  end

  assign matchVec = matchReg;
endmodule

// File: rtl/cam_top.sv
module cam_top
  import cam_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 9,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 loadArg,
  input  logic [WORD_W-1:0]    argIn,
  input  logic                 loadKey,
  input  logic [WORD_W-1:0]    keyIn,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [WORD_W-1:0]    wrData,
  input  logic                 wrValid,
  input  logic                 searchStb,
  input  logic                 rdStb,
  output logic [NUM_WORDS-1:0] matchVec,
  output logic [WORD_W-1:0]    rdData,
  output logic                 noMatch
);
  camStrobe_t strobes;

  cam_ctrl #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_ctrl (
    .loadArg(loadArg), .loadKey(loadKey), .wrEn(wrEn), .wrIdx(wrIdx),
    .searchStb(searchStb), .rdStb(rdStb), .strobes(strobes)
  );

  cam_datapath #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .argIn(argIn), .keyIn(keyIn),
    .wrIdx(wrIdx), .wrData(wrData), .wrValid(wrValid),
    .matchVec(matchVec), .rdData(rdData), .noMatch(noMatch)
  );
endmodule

// File: rtl/cam_checker.sv
module cam_checker #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 9,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wrEn,
  input logic [IDX_W-1:0]     wrIdx,
  input logic                 wrValid,
  input logic                 searchStb,
  input logic                 rdStb,
  input logic [NUM_WORDS-1:0] matchVec,
  input logic [WORD_W-1:0]    rdData,
  input logic                 noMatch
);
  localparam logic [IDX_W:0] ENTRY_LIMIT = (IDX_W + 1)'(NUM_WORDS);

  logic [NUM_WORDS-1:0] shadowValid;

  always_ff @(posedge clk) begin
    if (!rst_n) shadowValid <= '0;
    else if (wrEn && ({1'b0, wrIdx} < ENTRY_LIMIT)) shadowValid[wrIdx] <= wrValid;
  end

  AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !searchStb |=> $stable(matchVec)); // R5

  AST_INVALID_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    searchStb |=> ((matchVec & ~$past(shadowValid)) == '0)); // R4

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rdStb |=> ($stable(rdData) && $stable(noMatch))); // R7

  AST_READ_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && (matchVec != '0)) |=> !noMatch); // R7

  AST_READ_MISS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && (matchVec == '0)) |=> (noMatch && (rdData == '0))); // R8
endmodule

bind cam_top cam_checker #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .wrValid(wrValid),
  .searchStb(searchStb), .rdStb(rdStb), .matchVec(matchVec),
  .rdData(rdData), .noMatch(noMatch)
);

// File: tb/tb_cam_top.sv
module tb_cam_top;
  localparam int NW = 8;
  localparam int WW = 9;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          loadArg = 0, loadKey = 0, wrEn = 0, wrValid = 0, searchStb = 0, rdStb = 0;
  logic [WW-1:0] argIn = '0, keyIn = '0, wrData = '0;
  logic [IW-1:0] wrIdx = '0;
  logic [NW-1:0] matchVec;
  logic [WW-1:0] rdData;
  logic          noMatch;

  int compared = 0;
  int mismatched = 0;

  // reference model
  logic [WW-1:0] mData [NW];
  logic [NW-1:0] mValid;
  logic [WW-1:0] mArg, mKey, mRd;
  logic [NW-1:0] mMatch;
  logic          mNo;

  cam_top #(.NUM_WORDS(NW), .WORD_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .loadArg(loadArg), .argIn(argIn), .loadKey(loadKey),
    .keyIn(keyIn), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .wrValid(wrValid),
    .searchStb(searchStb), .rdStb(rdStb), .matchVec(matchVec), .rdData(rdData),
    .noMatch(noMatch)
  );

  always #10 clk = ~clk;

  function automatic logic [NW-1:0] expMatch();
    logic [NW-1:0] v = '0;
    for (int i = 0; i < NW; i++)
      v[i] = mValid[i] && (((mData[i] ^ mArg) & mKey) == '0);
    return v;
  endfunction

  function automatic logic [WW-1:0] expFirst(logic [NW-1:0] m);
    for (int i = 0; i < NW; i++) if (m[i]) return mData[i];
    return '0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NW; i++) mData[i] = '0;
    mValid = '0; mArg = '0; mKey = '0; mRd = '0; mMatch = '0; mNo = 1'b0;
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic cycle(input string tag);
    logic [NW-1:0] nMatch;
    @(posedge clk);
    nMatch = searchStb ? expMatch() : mMatch;
    if (rdStb) begin
      mRd = expFirst(mMatch);
      mNo = (mMatch == '0);
    end
    if (wrEn) begin
      mData[wrIdx]  = wrData;
      mValid[wrIdx] = wrValid;
    end
    if (loadArg) mArg = argIn;
    if (loadKey) mKey = keyIn;
    mMatch = nMatch;
    @(negedge clk);
    check({tag, " matchVec"}, 32'(matchVec), 32'(mMatch));
    check({tag, " rdData"},   32'(rdData),   32'(mRd));
    check({tag, " noMatch"},  32'(noMatch),  32'(mNo));
    {loadArg, loadKey, wrEn, searchStb, rdStb} = '0;
  endtask

  task automatic doWrite(input int idx, input logic [WW-1:0] d, input logic v, input string tag);
    wrEn = 1; wrIdx = IW'(idx); wrData = d; wrValid = v;
    cycle(tag);
  endtask

  task automatic doSetup(input logic [WW-1:0] a, input logic [WW-1:0] k);
    loadArg = 1; argIn = a; loadKey = 1; keyIn = k;
    cycle("R9 load");
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 matchVec", 32'(matchVec), 0);
    check("R1 rdData", 32'(rdData), 0);
    check("R1 noMatch", 32'(noMatch), 0);
    searchStb = 1; cycle("R1 no valid entry");

    // R10 worked example
    doWrite(0, 9'b100111100, 1, "R6 write");
    doWrite(1, 9'b101000011, 1, "R6 write");
    doSetup(9'b101111100, 9'b111000000);
    searchStb = 1; cycle("R10 search");
    check("R10 hit bits", 32'(matchVec), 32'h02);
    rdStb = 1; cycle("R7 read");
    check("R10 read data", 32'(rdData), 32'(9'b101000011));

    // R3 zero mask, all valid
    for (int i = 0; i < NW; i++) doWrite(i, WW'(i * 37 + 5), 1, "R6 fill");
    doSetup(9'h1AA, '0);
    searchStb = 1; cycle("R3 zero mask");
    check("R3 all hit", 32'(matchVec), 32'hFF);
    rdStb = 1; cycle("R7 lowest index");
    check("R7 lowest data", 32'(rdData), 32'(WW'(5)));

    // R4 invalidate entry 3, zero mask
    doWrite(3, 9'h0, 0, "R4 invalidate");
    searchStb = 1; cycle("R4 search");
    check("R4 bit3 clear", 32'(matchVec), 32'hF7);

    // R8 full mask, absent value
    doSetup(9'h1FF, 9'h1FF);
    searchStb = 1; cycle("R8 search");
    rdStb = 1; cycle("R8 read");
    check("R8 miss flag", 32'(noMatch), 1);

    // R5 hold without search
    doSetup(WW'(5), 9'h1FF);
    cycle("R5 hold");
    check("R5 unchanged", 32'(matchVec), 0);

    // R9 load and search same edge use old search value
    loadArg = 1; argIn = WW'(42); searchStb = 1; cycle("R9 same edge");
    check("R9 old value hit", 32'(matchVec), 32'h01);

    // R6 write and search same edge see old contents
    wrEn = 1; wrIdx = 0; wrData = 9'h100; wrValid = 1;
    loadArg = 1; argIn = WW'(42); searchStb = 1; cycle("R6 same edge");
    searchStb = 1; cycle("R6 after write");

    // R2 random traffic
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: begin wrEn = 1; wrIdx = IW'($urandom); wrData = WW'($urandom % 8); wrValid = ($urandom % 4) != 0; end
        1: begin loadArg = 1; argIn = WW'($urandom % 8); end
        2: begin loadKey = 1; keyIn = WW'($urandom); end
        3: searchStb = 1;
        4: rdStb = 1;
        default: begin searchStb = 1; rdStb = 1; loadKey = ($urandom % 2) != 0; keyIn = WW'($urandom % 8); end
      endcase
      cycle("R2 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule